// File: doc/BRIEF.md
# Open-Page DRAM Command Sequencer

This block turns simple word-burst requests into the command sequence of a DRAM-style device. The device has a narrow, time-shared address bus and four active-low strobes: chip select, row strobe, column strobe and write enable. Each request carries a 16-bit word address, a read/write flag and four words of write data. The sequencer splits the address into an upper half, used as the row, and a lower half, used as the column. The column is aligned down to a four-word boundary.

The sequencer remembers which row the device holds open. A request to that row goes straight to its column command. A request to a different row first closes the open row with a precharge and then activates the new one. A request that arrives when no row is open only needs the activate. Every column command moves four adjacent words. Write words are driven in the column cycle and the three cycles after it. Read words come back after a fixed CAS latency and are presented on a four-beat valid strobe. While a sequence is running, the request port holds off new work by dropping its ready signal.

States: IDLE (deselected, ready), PRE (precharge command), TRP (close-to-open wait), ACT (activate), TRCD (open-to-column wait), COL (column read or write), BURST (remaining data beats). Transitions: IDLE→COL on a hit, IDLE→PRE on a miss, IDLE→ACT with no row open, PRE→TRP→ACT, ACT→TRCD→COL, COL→BURST→IDLE.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after release, req_ready is 1, dev_cs_n is 1, the three strobes are 1, dev_dq_oe is 0 and rd_valid is 0.
- R2: Strobe code {cs_n, ras_n, cas_n, we_n}: activate 0011, column read 0101, column write 0100, precharge 0010, no-operation 0111, deselect 1111. With no row open, an accepted request yields an activate one cycle after acceptance, with dev_addr equal to req_addr[15:8].
- R3: The column command has dev_addr equal to req_addr[7:0] with bits [1:0] forced to zero. It is coded as read or write according to req_write.
- R4: A request whose row equals the open row issues its column command one cycle after acceptance, with no activate or precharge.
- R5: A request to a different row while a row is open issues a precharge one cycle after acceptance, an activate T_RP cycles after the precharge, and the column command T_RCD cycles after the activate.
- R6: For a write, dev_dq_oe is 1 in the column-command cycle and the three following cycles only. dev_dq_out carries req_wdata[15:0], [31:16], [47:32] and [63:48] in that order.
- R7: For a read, rd_valid is 1 for exactly four cycles, starting CAS_LAT+1 cycles after the column command. rd_data gives the device words in the order they arrived, which are the words sampled from dev_dq_in in the CAS_LAT-th through (CAS_LAT+3)-th cycles after the column command.
- R8: req_ready is 0 from the cycle after acceptance until the sequence ends. It returns to 1 four cycles after a write column command, and CAS_LAT+4 cycles after a read column command.
- R9: Wait and burst cycles carry the no-operation code. Idle cycles carry the deselect code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 16 | Word address, row in the upper byte |
| req_wdata | input | 64 | Four write words, first word in the low bits |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | 16 | Read beat data |
| dev_cs_n | output | 1 | Device select, active low |
| dev_ras_n | output | 1 | Row strobe, active low |
| dev_cas_n | output | 1 | Column strobe, active low |
| dev_we_n | output | 1 | Write enable, active low |
| dev_addr | output | 8 | Multiplexed row/column address |
| dev_dq_out | output | 16 | Write data to device |
| dev_dq_oe | output | 1 | Write data drive enable |
| dev_dq_in | input | 16 | Read data from device |

## Verification
Every result is timed from the acceptance cycle. The first command comes one cycle later. The activate follows T_RP after a precharge, and the column command follows T_RCD after an activate. Write beats occupy the column cycle plus three. Read beats appear CAS_LAT+1 to CAS_LAT+4 cycles after the column command, and ready returns in the last of them. The bench classifies each request as hit, miss or closed from its own record of the open row, derives these offsets, and compares every port at the falling edge of each cycle of the sequence. This covers the cycles where nothing should happen as well as those where something should.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_TRP, ST_ACT, ST_TRCD, ST_COL, ST_BURST
    } mpc_state_e;

    // {ras_n, cas_n, we_n} with select asserted
    localparam logic [2:0] STB_ACT  = 3'b011;
    localparam logic [2:0] STB_RD   = 3'b101;
    localparam logic [2:0] STB_WR   = 3'b100;
    localparam logic [2:0] STB_PRE  = 3'b010;
    localparam logic [2:0] STB_IDLE = 3'b111;
endpackage

// File: rtl/mpc_timer.sv
module mpc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/mpc_page_track.sv
module mpc_page_track #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_fire,
    input  logic [ROW_W-1:0] act_row,
    input  logic             pre_fire,
    input  logic [ROW_W-1:0] probe_row,
    output logic             page_open,
    output logic             probe_hit
);
    logic [ROW_W-1:0] open_row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_open <= 1'b0;
            open_row  <= '0;
        end else if (act_fire) begin
            page_open <= 1'b1;
            open_row  <= act_row;
        end else if (pre_fire) begin
            page_open <= 1'b0;
        end
    end

    assign probe_hit = page_open && (probe_row == open_row);

    AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> !page_open);                                   // R5
    AST_PRE_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        pre_fire |-> page_open);                                    // R5
endmodule

// File: rtl/mpc_rd_capture.sv
module mpc_rd_capture #(
    parameter int WORD_W    = 16,
    parameter int CAS_LAT   = 2,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [WORD_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    localparam int BEAT_W = $clog2(BURST_LEN) + 1;

    logic [CAS_LAT-1:0] issue_d;
    logic [BEAT_W-1:0]  beats_left;
    logic               start;

    generate
        if (CAS_LAT == 1) begin : g_lat1
            always_ff @(posedge clk or negedge rst_n)
                if (!rst_n) issue_d <= '0;
                else        issue_d <= issue;
        end else begin : g_latn
            always_ff @(posedge clk or negedge rst_n)
                if (!rst_n) issue_d <= '0;
                else        issue_d <= {issue_d[CAS_LAT-2:0], issue};
        end
    endgenerate

    assign start = issue_d[CAS_LAT-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_left <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else if (start) begin
            beats_left <= BEAT_W'(BURST_LEN - 1);
            rd_valid   <= 1'b1;
            rd_data    <= dq_in;
        end else if (beats_left != '0) begin
            beats_left <= beats_left - 1'b1;
            rd_valid   <= 1'b1;
            rd_data    <= dq_in;
        end else begin
            rd_valid   <= 1'b0;
        end
    end

    AST_RD_TWO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |=> rd_valid);                              // R7
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import mpc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WORD_W    = 16,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    parameter int T_RCD     = 2,
    parameter int CAS_LAT   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [WORD_W*BURST_LEN-1:0]   req_wdata,
    output logic                          rd_valid,
    output logic [WORD_W-1:0]             rd_data,
    output logic                          dev_cs_n,
    output logic                          dev_ras_n,
    output logic                          dev_cas_n,
    output logic                          dev_we_n,
    output logic [ADDR_W/2-1:0]           dev_addr,
    output logic [WORD_W-1:0]             dev_dq_out,
    output logic                          dev_dq_oe,
    input  logic [WORD_W-1:0]             dev_dq_in
);
    localparam int ROW_W   = ADDR_W / 2;
    localparam int COL_W   = ADDR_W - ROW_W;
    localparam int OFF_W   = $clog2(BURST_LEN);
    localparam int BEAT_W  = OFF_W + 1;
    localparam int TMR_MAX = (CAS_LAT + 2 > T_RP) ? ((CAS_LAT + 2 > T_RCD) ? CAS_LAT + 2 : T_RCD)
                                                  : ((T_RP > T_RCD) ? T_RP : T_RCD);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    mpc_state_e             state, state_nx;
    logic                   wr_q;
    logic [ROW_W-1:0]       row_q;
    logic [COL_W-1:0]       col_q;
    logic [WORD_W*BURST_LEN-1:0] wdata_q;
    logic [BEAT_W-1:0]      beat;
    logic                   accept, tmr_zero, tmr_load;
    logic [TMR_W-1:0]       tmr_val;
    logic                   page_open, probe_hit;
    logic [2:0]             stb;

    assign accept = req_valid && req_ready;

    mpc_page_track #(.ROW_W(ROW_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .act_fire(state == ST_ACT), .act_row(row_q),
        .pre_fire(state == ST_PRE),
        .probe_row(req_addr[ADDR_W-1:COL_W]),
        .page_open(page_open), .probe_hit(probe_hit)
    );

    always_comb begin
        tmr_load = 1'b1;
        unique case (state)
            ST_PRE:  tmr_val = TMR_W'(T_RP - 2);
            ST_ACT:  tmr_val = TMR_W'(T_RCD - 2);
            ST_COL:  tmr_val = wr_q ? TMR_W'(BURST_LEN - 2) : TMR_W'(CAS_LAT + BURST_LEN - 2);
            default: begin tmr_val = '0; tmr_load = 1'b0; end
        endcase
    end

    mpc_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    mpc_rd_capture #(.WORD_W(WORD_W), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)) u_cap (
        .clk(clk), .rst_n(rst_n), .issue((state == ST_COL) && !wr_q),
        .dq_in(dev_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = probe_hit ? ST_COL : (page_open ? ST_PRE : ST_ACT);
            ST_PRE:   state_nx = ST_TRP;
            ST_TRP:   if (tmr_zero) state_nx = ST_ACT;
            ST_ACT:   state_nx = ST_TRCD;
            ST_TRCD:  if (tmr_zero) state_nx = ST_COL;
            ST_COL:   state_nx = ST_BURST;
            ST_BURST: if (tmr_zero) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wr_q    <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
            beat    <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                wr_q    <= req_write;
                row_q   <= req_addr[ADDR_W-1:COL_W];
                col_q   <= {req_addr[COL_W-1:OFF_W], {OFF_W{1'b0}}};
                wdata_q <= req_wdata;
            end
            if (state == ST_COL || state == ST_BURST) beat <= beat + 1'b1;
            else                                      beat <= '0;
        end
    end

    always_comb begin
        req_ready  = 1'b0;
        dev_cs_n   = 1'b0;
        stb        = STB_IDLE;
        dev_addr   = '0;
        unique case (state)
            ST_IDLE: begin req_ready = 1'b1; dev_cs_n = 1'b1; end
            ST_PRE:  stb = STB_PRE;
            ST_ACT:  begin stb = STB_ACT; dev_addr = row_q; end
            ST_COL:  begin stb = wr_q ? STB_WR : STB_RD; dev_addr = col_q; end
            default: stb = STB_IDLE;
        endcase
        {dev_ras_n, dev_cas_n, dev_we_n} = stb;
        dev_dq_oe  = wr_q && (state == ST_COL || state == ST_BURST) && (beat < BEAT_W'(BURST_LEN));
        dev_dq_out = wdata_q[beat[OFF_W-1:0]*WORD_W +: WORD_W];
    end

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dev_cs_n |-> (dev_ras_n && dev_cas_n && dev_we_n));         // R9
    AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> dev_cs_n);                                    // R8
    AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_cs_n && dev_ras_n && !dev_cas_n) |-> page_open);      // R4
    AST_OE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        dev_dq_oe |-> !req_ready);                                  // R6
    AST_NO_RDV_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_dq_oe |-> !rd_valid);                                   // R7
endmodule

// File: tb/dram_page_ctrl_bench.sv
module dram_page_ctrl_bench;
    localparam int TRP = 3, TRCD = 2, CL = 2;
    localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                           C_PRE = 4'b0010, C_NOP = 4'b0111, C_DES = 4'b1111;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [15:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic req_ready, rd_valid, dev_cs_n, dev_ras_n, dev_cas_n, dev_we_n, dev_dq_oe;
    logic [15:0] rd_data, dev_dq_out;
    logic [15:0] dev_dq_in = '0;
    logic [7:0]  dev_addr;

    int total = 0, bad = 0;
    int cyc = 0;
    bit done = 0;
    bit b_open = 0;
    logic [7:0] b_row = '0, m_row = '0;
    logic [15:0] sch_w [16];
    bit          sch_v [16];

    dram_page_ctrl #(.T_RP(TRP), .T_RCD(TRCD), .CAS_LAT(CL)) u_dram_page_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dev_cs_n(dev_cs_n),
        .dev_ras_n(dev_ras_n), .dev_cas_n(dev_cas_n), .dev_we_n(dev_we_n),
        .dev_addr(dev_addr), .dev_dq_out(dev_dq_out), .dev_dq_oe(dev_dq_oe),
        .dev_dq_in(dev_dq_in)
    );

    always #2 clk = ~clk;

    function automatic logic [3:0] cmd_now();
        return {dev_cs_n, dev_ras_n, dev_cas_n, dev_we_n};
    endfunction

    function automatic logic [15:0] dev_word(logic [7:0] row, logic [7:0] col, int i);
        return {row, col + 8'(i)};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    // device model: answers read commands after CL cycles
    initial begin
        for (int i = 0; i < 16; i++) sch_v[i] = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cmd_now() == C_ACT) m_row = dev_addr;
            if (cmd_now() == C_RD)
                for (int i = 0; i < 4; i++) begin
                    sch_w[(cyc + CL + i) % 16] = dev_word(m_row, dev_addr, i);
                    sch_v[(cyc + CL + i) % 16] = 1;
                end
            dev_dq_in = sch_v[cyc % 16] ? sch_w[cyc % 16] : 16'hBEEF;
            sch_v[cyc % 16] = 0;
        end
    end

    task automatic run_req(bit w, logic [15:0] ad, logic [63:0] wd);
        logic [7:0] row, col;
        int pre_at, act_at, col_at, end_at;
        logic [3:0] ec;
        row = ad[15:8];
        col = {ad[7:2], 2'b00};
        @(negedge clk);
        check("R9 idle deselect", cmd_now(), C_DES);
        check("R8 idle ready", req_ready, 1);
        req_valid = 1; req_write = w; req_addr = ad; req_wdata = wd;
        if (b_open && b_row == row) begin pre_at = 0; act_at = 0; col_at = 1; end
        else if (b_open) begin pre_at = 1; act_at = 1 + TRP; col_at = act_at + TRCD; end
        else begin pre_at = 0; act_at = 1; col_at = 1 + TRCD; end
        end_at = w ? col_at + 4 : col_at + CL + 4;
        for (int k = 1; k <= end_at; k++) begin
            @(negedge clk);
            if (k == 1) begin req_valid = 0; req_addr = $urandom; req_wdata = {$urandom, $urandom}; end
            if (k == pre_at) ec = C_PRE;
            else if (k == act_at) ec = C_ACT;
            else if (k == col_at) ec = w ? C_WR : C_RD;
            else if (k == end_at) ec = C_DES;
            else ec = C_NOP;
            if (k == pre_at)      check("R5 precharge", cmd_now(), ec);
            else if (k == act_at) begin
                check(b_open ? "R5 activate" : "R2 activate", cmd_now(), ec);
                check("R2 row address", dev_addr, row);
            end else if (k == col_at) begin
                check(pre_at == 0 && act_at == 0 ? "R4 hit column" : "R3 column", cmd_now(), ec);
                check("R3 column address", dev_addr, col);
            end else check("R9 wait code", cmd_now(), ec);
            check("R8 ready", req_ready, (k == end_at));
            check("R6 oe", dev_dq_oe, w && k >= col_at && k < col_at + 4);
            if (w && k >= col_at && k < col_at + 4)
                check("R6 write word", dev_dq_out, wd[(k - col_at) * 16 +: 16]);
            check("R7 rd_valid", rd_valid, !w && k >= col_at + CL + 1 && k <= col_at + CL + 4);
            if (!w && k >= col_at + CL + 1 && k <= col_at + CL + 4)
                check("R7 read word", rd_data, dev_word(row, col, k - col_at - CL - 1));
        end
        b_open = 1; b_row = row;
    endtask

    initial begin
        int seed;
        logic [7:0] rows [3];
        rows[0] = 8'h12; rows[1] = 8'h34; rows[2] = 8'hA5;
        seed = $urandom(32'd20240607);
        repeat (3) begin
            @(negedge clk);
            check("R1 reset ready", req_ready, 1);
            check("R1 reset code", cmd_now(), C_DES);
            check("R1 reset oe/rdv", {dev_dq_oe, rd_valid}, 0);
        end
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", {req_ready, cmd_now(), dev_dq_oe, rd_valid}, {1'b1, C_DES, 2'b00});
        // directed: closed, hit, hit write, miss, boundary column
        run_req(0, 16'h124A, '0);
        run_req(0, 16'h124E, '0);
        run_req(1, 16'h1243, 64'h4444_3333_2222_1111);
        run_req(0, 16'h3407, '0);
        run_req(1, 16'h12FF, 64'hDDDD_CCCC_BBBB_AAAA);
        run_req(1, 16'h1200, 64'h0123_4567_89AB_CDEF);
        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [15:0] a;
            a = {rows[$urandom % 3], 8'($urandom)};
            run_req(1'($urandom), a, {$urandom, $urandom});
            if (($urandom % 4) == 0) repeat ($urandom % 3) @(negedge clk);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule